// File: doc/BRIEF.md
# DMA Translation Unit Configuration and Fault Registers

This block is the software-visible register bank of a DMA address-translation unit. A CPU reaches it through a 32-bit, word-addressed request port with a valid/ready handshake. Reads return data in the cycle after the request is accepted. Writes take effect at the accepting clock edge and produce no response. Each register stores only its writable bits. Some registers force fixed bits to one, and the chip-identification register gathers written bits by OR rather than replacing its contents. When the window-size field of the control register is written, the block turns it into the lowest address of the DMA window and exports that address to the translator.

The translator reports faults on a one-cycle strobe. The block then records a fixed fault-status pattern and the page address of the failing access, and raises a level interrupt. Software lowers the interrupt by reading or writing either the fault-status or the fault-address register. The port follows a two-state machine. In `ST_IDLE` the block is ready. An accepted read moves it to `ST_RESP` (the transition named *read-accept*), where the response is valid and `req_ready` is low. The block always returns to `ST_IDLE` on the next edge (the transition named *response-done*). A write leaves the block in `ST_IDLE` (*write-accept*).

Top module: `dmamap_csr`

## Requirements
- R1: After reset, the registers read as follows. Control reads VERSION in bits 31:24 with zeros below. Fault status reads 0x00800000. Bus-arbiter enable reads 0x00000003. Slot arbitration reads 0x00000008. Chip ID reads 0x23000000. Every other register reads 0. `win_start` is 0 and `irq` is low.
- R2: `req_ready` is high only in ST_IDLE. A read accepted at an edge gives `rsp_valid` high with its data for exactly the next cycle, and `req_ready` is low in that cycle. A write produces no `rsp_valid`.
- R3: Control is at byte offset 0x0000. It keeps the written bits under mask 0x0000001D, with enable in bit 0 and the window-size code in bits 4:2. Bits 31:24 always read VERSION.
- R4: Each control write loads `win_start` with 0xFFFFFFFF shifted left by 24 plus the window-size code. Code 0 gives 0xFF000000 (16 MB) and code 7 gives 0x80000000 (2 GB). No other event changes `win_start`.
- R5: Table base at 0x0004 keeps mask 0x07FFFC00. Full flush at 0x0014 and page flush at 0x0018 keep all 32 bits. The four slot configurations at 0x1010, 0x1014, 0x1018 and 0x101C each keep mask 0x00010003.
- R6: Bus-arbiter enable at 0x1008 keeps mask 0x801F000F and always has bit 0 set. Slot arbitration at 0x2000 keeps mask 0x001F0000 and always has bit 3 set.
- R7: Fault status at 0x1000 keeps the written bits under mask 0xFF0FFFFF and always has bit 23 set. Fault address at 0x1004 keeps all 32 bits.
- R8: A write to chip ID at 0x3018 ORs the low 24 bits of the data into its contents and never clears a bit.
- R9: A fault strobe loads fault status with 0xC0820000, or with 0xC0860000 when the failing access was a read (bit 18 set). It loads fault address with the reported address with bits 11:0 cleared, and sets `irq` from the next cycle on.
- R10: An accepted read or write of fault status or fault address lowers `irq` at that edge. Accesses to other registers leave `irq` unchanged.
- R11: When a fault strobe and a CPU access to fault status or fault address fall in the same cycle, the fault wins. Both registers take the fault values and `irq` stays high.
- R12: Any other word offset is plain 32-bit storage. The word offset modulo 2^SCR_AW selects one of 2^SCR_AW scratch words, so offsets that differ only above those bits share a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (14) | Byte address; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| flt_valid | input | 1 | Translator reports a fault this cycle |
| flt_is_read | input | 1 | The faulting access was a read |
| flt_addr | input | 32 | Address of the faulting access |
| win_start | output | 32 | Lowest address of the DMA window |
| irq | output | 1 | Fault interrupt, level |

## Verification
Random writes with full-width data go to every defined register and to undefined offsets. Each register is then read back and compared against a model built from the masks and forced bits. This separates a wrong mask from a missing forced bit and from a wrong address decode. Directed passes step through all eight window-size codes. They also drive two writes to chip ID that must accumulate, and raise faults on reads and on writes to tell the status patterns apart. Other directed cases set a fault and a status access in the same cycle, touch unrelated registers while the interrupt is pending, and write scratch offsets that alias onto the same word.

// File: rtl/dmamap_pkg.sv
package dmamap_pkg;
    localparam int DW   = 32;
    localparam int WA_W = 12;

    localparam logic [WA_W-1:0] WA_CTRL   = 12'h000;
    localparam logic [WA_W-1:0] WA_BASE   = 12'h001;
    localparam logic [WA_W-1:0] WA_TLBF   = 12'h005;
    localparam logic [WA_W-1:0] WA_PGF    = 12'h006;
    localparam logic [WA_W-1:0] WA_FSTS   = 12'h400;
    localparam logic [WA_W-1:0] WA_FADR   = 12'h401;
    localparam logic [WA_W-1:0] WA_AER    = 12'h402;
    localparam logic [WA_W-1:0] WA_SLOT0  = 12'h404;
    localparam logic [WA_W-1:0] WA_ARBEN  = 12'h800;
    localparam logic [WA_W-1:0] WA_CHIPID = 12'hC06;

    localparam logic [DW-1:0] M_CTRL   = 32'h0000_001D;
    localparam logic [DW-1:0] M_BASE   = 32'h07FF_FC00;
    localparam logic [DW-1:0] M_SLOT   = 32'h0001_0003;
    localparam logic [DW-1:0] M_ARBEN  = 32'h001F_0000;
    localparam logic [DW-1:0] F_ARBEN  = 32'h0000_0008;
    localparam logic [DW-1:0] M_AER    = 32'h801F_000F;
    localparam logic [DW-1:0] F_AER    = 32'h0000_0001;
    localparam logic [DW-1:0] R_AER    = 32'h0000_0003;
    localparam logic [DW-1:0] M_FSTS   = 32'hFF0F_FFFF;
    localparam logic [DW-1:0] F_FSTS   = 32'h0080_0000;
    localparam logic [DW-1:0] FLT_PAT  = 32'hC082_0000;
    localparam logic [DW-1:0] FLT_RDB  = 32'h0004_0000;
    localparam logic [DW-1:0] M_CHIPID = 32'h00FF_FFFF;
    localparam logic [DW-1:0] R_CHIPID = 32'h2300_0000;
    localparam logic [DW-1:0] PG_MASK  = 32'hFFFF_F000;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RESP
    } port_state_e;
endpackage

// File: rtl/dmamap_port.sv
module dmamap_port
    import dmamap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] rd_mux,
    output logic          req_ready,
    output logic          acc_wr,
    output logic          acc_rd,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    port_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && !req_write) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        acc_wr    = req_ready && req_valid && req_write;
        acc_rd    = req_ready && req_valid && !req_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (acc_rd) rsp_rdata <= rd_mux;
    end
endmodule

// File: rtl/dmamap_fault.sv
module dmamap_fault
    import dmamap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fsts,
    input  logic          wr_fadr,
    input  logic          touch,
    input  logic [DW-1:0] wdata,
    input  logic          flt_valid,
    input  logic          flt_is_read,
    input  logic [DW-1:0] flt_addr,
    output logic [DW-1:0] fsts_q,
    output logic [DW-1:0] fadr_q,
    output logic          irq_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsts_q <= F_FSTS;
            fadr_q <= '0;
            irq_q  <= 1'b0;
        end else if (flt_valid) begin
            fsts_q <= FLT_PAT | (flt_is_read ? FLT_RDB : '0);
            fadr_q <= flt_addr & PG_MASK;
            irq_q  <= 1'b1;
        end else begin
            if (wr_fsts) fsts_q <= (wdata & M_FSTS) | F_FSTS;
            if (wr_fadr) fadr_q <= wdata;
            if (touch)   irq_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/dmamap_csr.sv
module dmamap_csr
    import dmamap_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41,
    parameter int         ADDR_W  = 14,
    parameter int         SLOTS   = 4,
    parameter int         SCR_AW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    input  logic              flt_valid,
    input  logic              flt_is_read,
    input  logic [DW-1:0]     flt_addr,
    output logic [DW-1:0]     win_start,
    output logic              irq
);
    localparam int SCR_N = 1 << SCR_AW;

    logic [WA_W-1:0] wa;
    logic            acc_wr, acc_rd;
    logic [DW-1:0]   rd_mux;
    logic [DW-1:0]   fsts_q, fadr_q;
    logic [4:0]      ctrl_q;
    logic [DW-1:0]   base_q, tlbf_q, pgf_q, aer_q, arben_q, chipid_q, win_q;
    logic [DW-1:0]   slot_q [SLOTS];
    logic [DW-1:0]   scr_q  [SCR_N];
    logic [SLOTS-1:0] slot_hit;
    logic            fixed_hit, listed, fault_touch;

    assign wa = req_addr[WA_W+1:2];

    dmamap_port u_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .rd_mux(rd_mux), .req_ready(req_ready), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign fault_touch = (acc_wr || acc_rd) && (wa == WA_FSTS || wa == WA_FADR);

    dmamap_fault u_fault (
        .clk(clk), .rst_n(rst_n),
        .wr_fsts(acc_wr && wa == WA_FSTS), .wr_fadr(acc_wr && wa == WA_FADR),
        .touch(fault_touch), .wdata(req_wdata),
        .flt_valid(flt_valid), .flt_is_read(flt_is_read), .flt_addr(flt_addr),
        .fsts_q(fsts_q), .fadr_q(fadr_q), .irq_q(irq)
    );

    always_comb begin
        unique case (wa)
            WA_CTRL, WA_BASE, WA_TLBF, WA_PGF, WA_FSTS, WA_FADR,
            WA_AER, WA_ARBEN, WA_CHIPID: fixed_hit = 1'b1;
            default:                     fixed_hit = 1'b0;
        endcase
    end
    assign listed = fixed_hit || (|slot_hit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            base_q   <= '0;
            tlbf_q   <= '0;
            pgf_q    <= '0;
            aer_q    <= R_AER;
            arben_q  <= F_ARBEN;
            chipid_q <= R_CHIPID;
            win_q    <= '0;
        end else if (acc_wr) begin
            unique case (wa)
                WA_CTRL: begin
                    ctrl_q <= req_wdata[4:0] & M_CTRL[4:0];
                    win_q  <= 32'hFFFF_FFFF << (5'd24 + {2'b00, req_wdata[4:2]});
                end
                WA_BASE:   base_q   <= req_wdata & M_BASE;
                WA_TLBF:   tlbf_q   <= req_wdata;
                WA_PGF:    pgf_q    <= req_wdata;
                WA_AER:    aer_q    <= (req_wdata & M_AER) | F_AER;
                WA_ARBEN:  arben_q  <= (req_wdata & M_ARBEN) | F_ARBEN;
                WA_CHIPID: chipid_q <= chipid_q | (req_wdata & M_CHIPID);
                default: ;
            endcase
        end
    end
    assign win_start = win_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [WA_W-1:0] MY_WA = WA_W'(int'(WA_SLOT0) + g);
        assign slot_hit[g] = (wa == MY_WA);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    slot_q[g] <= '0;
            else if (acc_wr && slot_hit[g]) slot_q[g] <= req_wdata & M_SLOT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SCR_N; i++) scr_q[i] <= '0;
        end else if (acc_wr && !listed) begin
            scr_q[wa[SCR_AW-1:0]] <= req_wdata;
        end
    end

    always_comb begin
        rd_mux = scr_q[wa[SCR_AW-1:0]];
        unique case (wa)
            WA_CTRL:   rd_mux = {VERSION, 19'b0, ctrl_q};
            WA_BASE:   rd_mux = base_q;
            WA_TLBF:   rd_mux = tlbf_q;
            WA_PGF:    rd_mux = pgf_q;
            WA_FSTS:   rd_mux = fsts_q;
            WA_FADR:   rd_mux = fadr_q;
            WA_AER:    rd_mux = aer_q;
            WA_ARBEN:  rd_mux = arben_q;
            WA_CHIPID: rd_mux = chipid_q;
            default: begin
                for (int i = 0; i < SLOTS; i++)
                    if (slot_hit[i]) rd_mux = slot_q[i];
            end
        endcase
    end
endmodule

// File: rtl/dmamap_chk.sv
module dmamap_chk
    import dmamap_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              flt_valid,
    input logic              irq,
    input logic [DW-1:0]     win_start
);
    logic acc, touch_fault, ctrl_wr;
    assign acc         = req_valid && req_ready;
    assign touch_fault = acc && (req_addr[WA_W+1:2] == WA_FSTS || req_addr[WA_W+1:2] == WA_FADR);
    assign ctrl_wr     = acc && req_write && req_addr[WA_W+1:2] == WA_CTRL;

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write) |=> rsp_valid); // R2
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R2
    AST_RESP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write) |=> !rsp_valid); // R2
    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(win_start)); // R4
    AST_WIN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        win_start[23:0] == 24'h0); // R4
    AST_FAULT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> irq); // R9
    AST_TOUCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_fault && !flt_valid) |=> !irq); // R10
    AST_OTHER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!touch_fault && !flt_valid) |=> $stable(irq)); // R10
endmodule

bind dmamap_csr dmamap_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dmamap_csr.sv
module sim_dmamap_csr;
    import dmamap_pkg::*;

    localparam logic [7:0] VER = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready, rsp_valid, irq;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0, rsp_rdata, win_start;
    logic        flt_valid = 1'b0, flt_is_read = 1'b0;
    logic [31:0] flt_addr = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dmamap_csr #(.VERSION(VER)) u0 (.*);

    // Expected state, built from the requirements
    logic [31:0] m_ctrl, m_base, m_tlbf, m_pgf, m_fsts, m_fadr, m_aer, m_arben, m_cid, m_win;
    logic [31:0] m_slot [4];
    logic [31:0] m_scr  [8];
    logic        m_irq;

    logic [11:0] listed_wa [14] = '{12'h000, 12'h001, 12'h005, 12'h006, 12'h400, 12'h401,
                                    12'h402, 12'h404, 12'h405, 12'h406, 12'h407, 12'h800,
                                    12'hC06, 12'h000};

    task automatic mdl_reset();
        m_ctrl = 0; m_base = 0; m_tlbf = 0; m_pgf = 0; m_fsts = 32'h0080_0000;
        m_fadr = 0; m_aer = 32'h3; m_arben = 32'h8; m_cid = 32'h2300_0000;
        m_win = 0; m_irq = 0;
        for (int i = 0; i < 4; i++) m_slot[i] = 0;
        for (int i = 0; i < 8; i++) m_scr[i] = 0;
    endtask

    task automatic mdl_write(input logic [11:0] wa, input logic [31:0] d);
        case (wa)
            12'h000: begin m_ctrl = d & 32'h1D; m_win = 32'hFFFF_FFFF << (24 + int'(d[4:2])); end
            12'h001: m_base = d & 32'h07FF_FC00;
            12'h005: m_tlbf = d;
            12'h006: m_pgf = d;
            12'h400: begin m_fsts = (d & 32'hFF0F_FFFF) | 32'h0080_0000; m_irq = 0; end
            12'h401: begin m_fadr = d; m_irq = 0; end
            12'h402: m_aer = (d & 32'h801F_000F) | 32'h1;
            12'h404, 12'h405, 12'h406, 12'h407: m_slot[wa[1:0]] = d & 32'h0001_0003;
            12'h800: m_arben = (d & 32'h001F_0000) | 32'h8;
            12'hC06: m_cid = m_cid | (d & 32'h00FF_FFFF);
            default: m_scr[wa[2:0]] = d;
        endcase
    endtask

    function automatic logic [31:0] mdl_read(input logic [11:0] wa);
        case (wa)
            12'h000: return {VER, 24'h0} | m_ctrl;
            12'h001: return m_base;
            12'h005: return m_tlbf;
            12'h006: return m_pgf;
            12'h400: return m_fsts;
            12'h401: return m_fadr;
            12'h402: return m_aer;
            12'h404, 12'h405, 12'h406, 12'h407: return m_slot[wa[1:0]];
            12'h800: return m_arben;
            12'hC06: return m_cid;
            default: return m_scr[wa[2:0]];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] wa, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = {wa, 2'b00}; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        mdl_write(wa, d);
    endtask

    task automatic do_read(input logic [11:0] wa, input string req);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = {wa, 2'b00};
        @(negedge clk);
        req_valid = 0;
        check("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        check("R2 ready low", {31'b0, req_ready}, 32'd0);
        check(req, rsp_rdata, mdl_read(wa));
        if (wa == 12'h400 || wa == 12'h401) m_irq = 0;
    endtask

    task automatic do_fault(input logic rd, input logic [31:0] a);
        @(negedge clk);
        flt_valid = 1; flt_is_read = rd; flt_addr = a;
        @(negedge clk);
        flt_valid = 0;
        m_fsts = 32'hC082_0000 | (rd ? 32'h0004_0000 : 32'h0);
        m_fadr = a & 32'hFFFF_F000;
        m_irq = 1;
    endtask

    task automatic chk_side(input string req);
        check({req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        check({req, " win_start"}, win_start, m_win);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", {31'b0, req_ready}, 32'd1);
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk_side("R1");
        for (int i = 0; i < 13; i++) do_read(listed_wa[i], "R1 reset value");
        do_read(12'h123, "R1 scratch reset");

        // R2 a write gives no response
        do_write(12'h005, 32'hDEAD_BEEF);
        check("R2 no rsp on write", {31'b0, rsp_valid}, 32'd0);

        // R3 and R4 every window code
        for (int c = 0; c < 8; c++) begin
            do_write(12'h000, 32'hFFFF_FFE2 | (32'(c) << 2));
            chk_side("R4");
            do_read(12'h000, "R3 ctrl");
        end

        // R5 to R7 all-ones data
        do_write(12'h001, 32'hFFFF_FFFF); do_read(12'h001, "R5 base");
        do_write(12'h406, 32'hFFFF_FFFF); do_read(12'h406, "R5 slot2");
        do_write(12'h402, 32'h0);         do_read(12'h402, "R6 aer forced");
        do_write(12'h800, 32'hFFFF_FFFF); do_read(12'h800, "R6 arben");
        do_write(12'h400, 32'h0);         do_read(12'h400, "R7 fsts forced");

        // R8 accumulation
        do_write(12'hC06, 32'hFF00_00F0);
        do_write(12'hC06, 32'h0000_000F);
        do_read(12'hC06, "R8 chip id or");

        // R9 faults, read and write kinds
        do_fault(1'b1, 32'hFF12_3ABC);
        chk_side("R9");
        do_write(12'h001, 32'h0000_0400);
        chk_side("R10 other write keeps irq");
        do_read(12'h402, "R10 other read");
        chk_side("R10 other read keeps irq");
        do_read(12'h400, "R9 fsts read fault");
        chk_side("R10 read clears");
        do_fault(1'b0, 32'hF000_1FFF);
        do_read(12'h401, "R9 fadr page");
        chk_side("R10 fadr read clears");
        do_fault(1'b0, 32'h1234_5678);
        do_write(12'h401, 32'h0BAD_F00D);
        chk_side("R10 fadr write clears");

        // R11 fault and status write in the same cycle
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = {12'h400, 2'b00}; req_wdata = 32'h0;
        flt_valid = 1; flt_is_read = 1; flt_addr = 32'hFE00_5123;
        @(negedge clk);
        req_valid = 0; req_write = 0; flt_valid = 0;
        m_fsts = 32'hC086_0000; m_fadr = 32'hFE00_5000; m_irq = 1;
        chk_side("R11");
        do_read(12'h401, "R11 fadr fault wins");
        do_fault(1'b0, 32'h0);
        do_read(12'h400, "R11 fsts write-kind fault");

        // R12 aliasing scratch words
        do_write(12'h103, 32'hAAAA_5555);
        do_write(12'h10B, 32'h1357_9BDF);
        do_read(12'h103, "R12 alias");
        do_read(12'h200, "R12 other word");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [11:0] wa;
            op = int'($urandom % 5);
            if ($urandom % 3 == 0) wa = 12'h100 + 12'($urandom % 64);
            else                   wa = listed_wa[$urandom % 13];
            case (op)
                0, 1: do_write(wa, $urandom);
                2, 3: do_read(wa, "R12/R5 random read");
                default: do_fault(1'($urandom), $urandom);
            endcase
            chk_side("R4/R10 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule